// File: doc/BRIEF.md
# Companion-Core Table Access Event Detector

This block sits beside the lookup-table RAM port of one processor core. It watches that port for reads or writes made by the core's paired partner, which is the core whose index differs from this core's index only in bit 0. When the partner touches one chosen address at the top of the table, the block raises a sticky event. The owning core can test the event (poll), stall until it occurs (wait), or discard it by writing a new configuration word.

A five-bit configuration word sets three things: the event source mode, whether reads or writes are watched, and which of the four highest table addresses is watched. A separate one-bit permission register controls whether the partner may write into this core's table. The block drives the write grant that the RAM uses. A partner write that is refused can never raise an event.

The behaviour is a five-state machine:
- `ST_OFF`: the source is disabled.
- `ST_WATCH`: the source is armed and no event is pending.
- `ST_WAIT`: the owner is stalled waiting for the event.
- `ST_PEND`: an event is held.
- `ST_WAKE`: a one-cycle state that releases a finished wait.

The transitions are:
- Any configuration write goes to `ST_WATCH` when the mode field is 11, and to `ST_OFF` otherwise. This takes priority over every other transition.
- `ST_WATCH` goes to `ST_PEND` on a hit, to `ST_WAIT` on a wait request, and to `ST_WAKE` on both at once.
- `ST_WAIT` goes to `ST_WAKE` on a hit.
- `ST_PEND` goes to `ST_WAKE` on a wait request. It goes to `ST_WATCH` on a poll with no hit in that cycle.
- `ST_WAKE` goes to `ST_PEND` on a hit, and to `ST_WATCH` otherwise.

Top module: `lut_share_event`

## Requirements
- R1: After reset the event flag, wake and waiting outputs are 0 and the write permission is 0, so a partner write receives no grant.
- R2: The watched address is the table address whose upper ADDR_W-2 bits are all ones and whose low two bits equal configuration bits 1..0 (0x1FC to 0x1FF for 9-bit addresses). No other address raises the event.
- R3: The event source is active only when configuration bits 3..2 equal 11. Any other value never raises the event.
- R4: Configuration bit 4 selects the direction: 0 watches reads and 1 watches writes. An access in the other direction raises no event.
- R5: Only accesses whose core index equals self_id XOR 1 raise the event. Accesses by the owning core and by any other core never do.
- R6: The write grant is 1 for the owning core's writes. For a partner write it is 1 only while the permission bit is 1. It is 0 for all other accesses. A partner write made while permission is 0 raises no event.
- R7: The event flag rises at the clock edge that samples a qualifying access. It then stays set until it is cleared.
- R8: A poll clears the flag at the next edge. If a qualifying access occurs in the same cycle as the poll, the flag stays set.
- R9: A wait request while no event is pending sets waiting from the next cycle. After the edge that samples a hit, wake and flag are both 1 for one cycle, and then both return to 0 unless a new hit occurs.
- R10: A wait request while the flag is set makes wake 1 in the next cycle.
- R11: A configuration write clears any pending event and any wait at the next edge. The new fields take effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_id | input | CORE_W | Index of the owning core |
| cfg_wr | input | 1 | Load the configuration word |
| cfg_data | input | 5 | Bit 4 direction, bits 3..2 mode, bits 1..0 address select |
| perm_wr | input | 1 | Load the write permission bit |
| perm_val | input | 1 | New write permission value |
| acc_valid | input | 1 | A table access is present |
| acc_we | input | 1 | The access is a write |
| acc_core | input | CORE_W | Index of the accessing core |
| acc_addr | input | ADDR_W | Table address of the access |
| poll | input | 1 | The owner tests and clears the event |
| wait_req | input | 1 | The owner starts waiting for the event |
| lut_wr_grant | output | 1 | The write may reach the RAM |
| evt_flag | output | 1 | The event is pending |
| evt_wake | output | 1 | A wait has completed (one cycle) |
| evt_waiting | output | 1 | The owner is waiting |

## Verification
The bench builds the block with its default parameters: 9-bit table addresses and 3-bit core indices. With these values all four watched addresses 0x1FC to 0x1FF can be reached, as can near-miss addresses in the lower half of the table. Eight core indices are available, so the owner, its partner and two unrelated cores can all be driven. The owner's index is also changed at run time, so that the XOR-1 pairing is tested in both directions (owner 5 with partner 4, and owner 2 with partner 3).

// File: rtl/lut_evt_pkg.sv
package lut_evt_pkg;
    localparam int CFG_W    = 5;
    localparam int SEL_W    = 2;
    localparam int SEL_LO   = 0;
    localparam int MODE_LO  = 2;
    localparam int DIR_BIT  = 4;
    localparam logic [1:0] MODE_COMPANION = 2'b11;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WATCH,
        ST_WAIT,
        ST_PEND,
        ST_WAKE
    } evt_state_e;
endpackage

// File: rtl/lut_evt_cfg.sv
module lut_evt_cfg
    import lut_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             perm_wr,
    input  logic             perm_val,
    output logic [SEL_W-1:0] sel,
    output logic [1:0]       mode,
    output logic             dir_wr,
    output logic             perm
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel    <= '0;
            mode   <= '0;
            dir_wr <= 1'b0;
        end else if (cfg_wr) begin
            sel    <= cfg_data[SEL_LO +: SEL_W];
            mode   <= cfg_data[MODE_LO +: 2];
            dir_wr <= cfg_data[DIR_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       perm <= 1'b0;
        else if (perm_wr) perm <= perm_val;
    end

    // R1: permission is 0 right after reset
    p_perm_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> !perm);
endmodule

// File: rtl/lut_evt_match.sv
module lut_evt_match
    import lut_evt_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int CORE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CORE_W-1:0] self_id,
    input  logic              acc_valid,
    input  logic              acc_we,
    input  logic [CORE_W-1:0] acc_core,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [SEL_W-1:0]  sel,
    input  logic [1:0]        mode,
    input  logic              dir_wr,
    input  logic              perm,
    output logic              hit,
    output logic              wr_grant
);
    localparam int UPPER_W = ADDR_W - SEL_W;

    logic [CORE_W-1:0] partner_id;
    logic [ADDR_W-1:0] target;
    logic              is_partner, is_owner, addr_eq, rd_ok, wr_ok;

    always_comb begin
        partner_id = self_id ^ CORE_W'(1);
        is_partner = (acc_core == partner_id);
        is_owner   = (acc_core == self_id);
        target     = {{UPPER_W{1'b1}}, sel};
        addr_eq    = (acc_addr == target);
        rd_ok      = acc_valid && !acc_we && !dir_wr;
        wr_ok      = acc_valid &&  acc_we &&  dir_wr && perm;
        hit        = (mode == MODE_COMPANION) && is_partner && addr_eq && (rd_ok || wr_ok);
        wr_grant   = acc_valid && acc_we && (is_owner || (is_partner && perm));
    end

    // R3: a disabled mode never produces a hit
    p_mode_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_COMPANION) |-> !hit);
    // R5: the owning core never triggers
    p_owner_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_core == self_id) |-> !hit);
    // R6: without permission only the owner may write
    p_perm_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_we && acc_core != self_id && !perm) |-> !wr_grant);
endmodule

// File: rtl/lut_evt_fsm.sv
module lut_evt_fsm
    import lut_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [1:0] new_mode,
    input  logic       hit,
    input  logic       poll,
    input  logic       wait_req,
    output logic       evt_flag,
    output logic       evt_wake,
    output logic       evt_waiting
);
    evt_state_e st, st_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        if (cfg_wr) begin
            st_nxt = (new_mode == MODE_COMPANION) ? ST_WATCH : ST_OFF;
        end else begin
            unique case (st)
                ST_OFF:   st_nxt = ST_OFF;
                ST_WATCH: begin
                    if (hit)           st_nxt = wait_req ? ST_WAKE : ST_PEND;
                    else if (wait_req) st_nxt = ST_WAIT;
                end
                ST_WAIT:  if (hit) st_nxt = ST_WAKE;
                ST_PEND: begin
                    if (wait_req)          st_nxt = ST_WAKE;
                    else if (poll && !hit) st_nxt = ST_WATCH;
                end
                ST_WAKE:  st_nxt = hit ? ST_PEND : ST_WATCH;
            endcase
        end
    end

    always_comb begin
        evt_flag    = (st == ST_PEND) || (st == ST_WAKE);
        evt_wake    = (st == ST_WAKE);
        evt_waiting = (st == ST_WAIT);
    end

    // R7: a pending flag holds while nothing clears it
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag && !evt_wake && !poll && !wait_req && !cfg_wr) |=> evt_flag);
    // R8: poll clears unless a new hit arrives in the same cycle
    p_poll_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PEND && poll && !wait_req && !cfg_wr) |=> (evt_flag == $past(hit)));
    // R9: a waiting owner wakes after a hit, for one cycle only
    p_wait_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_waiting && hit && !cfg_wr) |=> evt_wake);
    p_wake_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_wake |=> !evt_wake);
    // R10: waiting on a pending event completes at once
    p_pend_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PEND && wait_req && !cfg_wr) |=> evt_wake);
    // R11: a configuration write drops the event and the wait
    p_cfg_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (!evt_flag && !evt_waiting));
endmodule

// File: rtl/lut_share_event.sv
module lut_share_event
    import lut_evt_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int CORE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CORE_W-1:0] self_id,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              perm_wr,
    input  logic              perm_val,
    input  logic              acc_valid,
    input  logic              acc_we,
    input  logic [CORE_W-1:0] acc_core,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              poll,
    input  logic              wait_req,
    output logic              lut_wr_grant,
    output logic              evt_flag,
    output logic              evt_wake,
    output logic              evt_waiting
);
    logic [SEL_W-1:0] sel;
    logic [1:0]       mode;
    logic             dir_wr, perm, hit;

    lut_evt_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_data (cfg_data),
        .perm_wr  (perm_wr),
        .perm_val (perm_val),
        .sel      (sel),
        .mode     (mode),
        .dir_wr   (dir_wr),
        .perm     (perm)
    );

    lut_evt_match #(.ADDR_W(ADDR_W), .CORE_W(CORE_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .self_id   (self_id),
        .acc_valid (acc_valid),
        .acc_we    (acc_we),
        .acc_core  (acc_core),
        .acc_addr  (acc_addr),
        .sel       (sel),
        .mode      (mode),
        .dir_wr    (dir_wr),
        .perm      (perm),
        .hit       (hit),
        .wr_grant  (lut_wr_grant)
    );

    lut_evt_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .new_mode    (cfg_data[MODE_LO +: 2]),
        .hit         (hit),
        .poll        (poll),
        .wait_req    (wait_req),
        .evt_flag    (evt_flag),
        .evt_wake    (evt_wake),
        .evt_waiting (evt_waiting)
    );
endmodule

// File: tb/tb_lut_share_event.sv
module tb_lut_share_event;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] self_id;
    logic       cfg_wr;
    logic [4:0] cfg_data;
    logic       perm_wr, perm_val;
    logic       acc_valid, acc_we;
    logic [2:0] acc_core;
    logic [8:0] acc_addr;
    logic       poll, wait_req;
    logic       lut_wr_grant, evt_flag, evt_wake, evt_waiting;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lut_share_event dut (
        .clk(clk), .rst_n(rst_n), .self_id(self_id), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .perm_wr(perm_wr), .perm_val(perm_val), .acc_valid(acc_valid), .acc_we(acc_we),
        .acc_core(acc_core), .acc_addr(acc_addr), .poll(poll), .wait_req(wait_req),
        .lut_wr_grant(lut_wr_grant), .evt_flag(evt_flag), .evt_wake(evt_wake),
        .evt_waiting(evt_waiting)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] cw(input logic d, input logic [1:0] m, input logic [1:0] s);
        return {d, m, s};
    endfunction

    task automatic set_cfg(input logic [4:0] v);
        cfg_wr = 1'b1; cfg_data = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic set_perm(input logic v);
        perm_wr = 1'b1; perm_val = v;
        @(negedge clk);
        perm_wr = 1'b0;
    endtask

    task automatic access(input logic [2:0] c, input logic we, input logic [8:0] a,
                          output logic g);
        acc_valid = 1'b1; acc_we = we; acc_core = c; acc_addr = a;
        #1 g = lut_wr_grant;
        @(negedge clk);
        acc_valid = 1'b0; acc_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic g;
        chk("R1 flag", evt_flag, 1'b0);
        chk("R1 wake", evt_wake, 1'b0);
        chk("R1 waiting", evt_waiting, 1'b0);
        access(3'd4, 1'b1, 9'h1FC, g);
        chk("R1 partner write grant", g, 1'b0);
    endtask

    task automatic t_addr;
        logic g;
        for (int s = 0; s < 4; s++) begin
            set_cfg(cw(1'b0, 2'b11, 2'(s)));
            access(3'd4, 1'b0, 9'h1FC + 9'((s + 1) % 4), g);
            chk("R2 other top address", evt_flag, 1'b0);
            access(3'd4, 1'b0, 9'h0FC + 9'(s), g);
            chk("R2 low-half alias", evt_flag, 1'b0);
            access(3'd4, 1'b0, 9'h1FC + 9'(s), g);
            chk("R2 selected address", evt_flag, 1'b1);
        end
    endtask

    task automatic t_mode;
        logic g;
        for (int m = 0; m < 3; m++) begin
            set_cfg(cw(1'b0, 2'(m), 2'd1));
            access(3'd4, 1'b0, 9'h1FD, g);
            chk("R3 inactive mode", evt_flag, 1'b0);
        end
        set_cfg(cw(1'b0, 2'b11, 2'd1));
        access(3'd4, 1'b0, 9'h1FD, g);
        chk("R3 active mode", evt_flag, 1'b1);
    endtask

    task automatic t_dir;
        logic g;
        set_perm(1'b1);
        set_cfg(cw(1'b0, 2'b11, 2'd0));
        access(3'd4, 1'b1, 9'h1FC, g);
        chk("R4 write ignored in read mode", evt_flag, 1'b0);
        access(3'd4, 1'b0, 9'h1FC, g);
        chk("R4 read mode fires", evt_flag, 1'b1);
        set_cfg(cw(1'b1, 2'b11, 2'd0));
        access(3'd4, 1'b0, 9'h1FC, g);
        chk("R4 read ignored in write mode", evt_flag, 1'b0);
        access(3'd4, 1'b1, 9'h1FC, g);
        chk("R4 write mode fires", evt_flag, 1'b1);
        set_perm(1'b0);
    endtask

    task automatic t_core;
        logic g;
        set_cfg(cw(1'b0, 2'b11, 2'd3));
        access(3'd5, 1'b0, 9'h1FF, g);
        chk("R5 owner ignored", evt_flag, 1'b0);
        access(3'd7, 1'b0, 9'h1FF, g);
        chk("R5 core 7 ignored", evt_flag, 1'b0);
        access(3'd1, 1'b0, 9'h1FF, g);
        chk("R5 core 1 ignored", evt_flag, 1'b0);
        access(3'd4, 1'b0, 9'h1FF, g);
        chk("R5 partner 4 fires", evt_flag, 1'b1);
        self_id = 3'd2;
        set_cfg(cw(1'b0, 2'b11, 2'd3));
        access(3'd4, 1'b0, 9'h1FF, g);
        chk("R5 old partner ignored", evt_flag, 1'b0);
        access(3'd3, 1'b0, 9'h1FF, g);
        chk("R5 partner 3 fires", evt_flag, 1'b1);
        self_id = 3'd5;
    endtask

    task automatic t_perm;
        logic g;
        set_perm(1'b0);
        set_cfg(cw(1'b1, 2'b11, 2'd2));
        access(3'd4, 1'b1, 9'h1FE, g);
        chk("R6 blocked partner grant", g, 1'b0);
        chk("R6 blocked write no event", evt_flag, 1'b0);
        access(3'd5, 1'b1, 9'h1FE, g);
        chk("R6 owner grant", g, 1'b1);
        access(3'd6, 1'b1, 9'h1FE, g);
        chk("R6 foreign grant", g, 1'b0);
        set_perm(1'b1);
        access(3'd4, 1'b1, 9'h1FE, g);
        chk("R6 permitted partner grant", g, 1'b1);
        chk("R6 permitted write event", evt_flag, 1'b1);
        set_perm(1'b0);
    endtask

    task automatic t_sticky_poll;
        logic g;
        set_cfg(cw(1'b0, 2'b11, 2'd0));
        access(3'd4, 1'b0, 9'h1FC, g);
        idle(5);
        chk("R7 flag held", evt_flag, 1'b1);
        poll = 1'b1; @(negedge clk); poll = 1'b0;
        chk("R8 poll clears", evt_flag, 1'b0);
        access(3'd4, 1'b0, 9'h1FC, g);
        poll = 1'b1;
        access(3'd4, 1'b0, 9'h1FC, g);
        poll = 1'b0;
        chk("R8 poll with hit keeps flag", evt_flag, 1'b1);
        poll = 1'b1; @(negedge clk); poll = 1'b0;
        chk("R8 second poll clears", evt_flag, 1'b0);
    endtask

    task automatic t_wait;
        logic g;
        set_cfg(cw(1'b0, 2'b11, 2'd1));
        wait_req = 1'b1; @(negedge clk); wait_req = 1'b0;
        chk("R9 waiting set", evt_waiting, 1'b1);
        chk("R9 no flag yet", evt_flag, 1'b0);
        idle(3);
        chk("R9 still waiting", evt_waiting, 1'b1);
        access(3'd4, 1'b0, 9'h1FD, g);
        chk("R9 wake", evt_wake, 1'b1);
        chk("R9 flag with wake", evt_flag, 1'b1);
        chk("R9 wait over", evt_waiting, 1'b0);
        idle(1);
        chk("R9 wake drops", evt_wake, 1'b0);
        chk("R9 flag drops", evt_flag, 1'b0);
    endtask

    task automatic t_wait_pend;
        logic g;
        access(3'd4, 1'b0, 9'h1FD, g);
        chk("R10 flag pending", evt_flag, 1'b1);
        wait_req = 1'b1; @(negedge clk); wait_req = 1'b0;
        chk("R10 immediate wake", evt_wake, 1'b1);
        idle(1);
        chk("R10 flag cleared after wake", evt_flag, 1'b0);
    endtask

    task automatic t_cfg;
        logic g;
        set_cfg(cw(1'b0, 2'b11, 2'd0));
        access(3'd4, 1'b0, 9'h1FC, g);
        chk("R11 flag before reconfig", evt_flag, 1'b1);
        set_cfg(cw(1'b0, 2'b11, 2'd3));
        chk("R11 reconfig clears flag", evt_flag, 1'b0);
        access(3'd4, 1'b0, 9'h1FC, g);
        chk("R11 old address dead", evt_flag, 1'b0);
        access(3'd4, 1'b0, 9'h1FF, g);
        chk("R11 new address live", evt_flag, 1'b1);
        set_cfg(cw(1'b0, 2'b11, 2'd3));
        wait_req = 1'b1; @(negedge clk); wait_req = 1'b0;
        chk("R11 waiting before reconfig", evt_waiting, 1'b1);
        set_cfg(cw(1'b0, 2'b11, 2'd3));
        chk("R11 reconfig cancels wait", evt_waiting, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; self_id = 3'd5; cfg_wr = 1'b0; cfg_data = '0;
        perm_wr = 1'b0; perm_val = 1'b0; acc_valid = 1'b0; acc_we = 1'b0;
        acc_core = '0; acc_addr = '0; poll = 1'b0; wait_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr();
        t_mode();
        t_dir();
        t_core();
        t_perm();
        t_sticky_poll();
        t_wait();
        t_wait_pend();
        t_cfg();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule